// File: doc/BRIEF.md
# Thread Yield Execution Controller

This block executes the thread-yield instruction of a multithreaded core that holds a small, fixed set of hardware thread contexts. Each cycle it looks at one instruction word, qualified by a valid strobe. When that word is a yield, the block decides what happens to the issuing context. The 32-bit operand value selects the outcome. Zero releases the context. All-ones hands control to the scheduler and leaves the context runnable. The value two below zero (all-ones minus one) only samples the qualifier inputs. A positive value parks the context until one of the named qualifier conditions becomes true.

Alongside the operand, the block uses the status of every context, the qualifier enable mask, and two scheduler-intercept enables: one for the virtual processor and one for the current context. From these it produces one registered, single-cycle result. That result is exactly one of three things: an action with its kind, a thread exception with a 3-bit cause, or a reserved-instruction exception. For an action it can also request a register write carrying the masked qualifier inputs. Scheduling policy and pipeline control belong to the surrounding core.

Top module: `thread_yield_ctrl`

## Requirements
- R1: A word is treated as a yield only when bits [31:26] are 0, bits [15:14] are 0, bits [13:6] are 8'h26 and bits [5:0] are 6'h3C. The destination index is bits [20:16]. Any other word produces no output.
- R2: All outputs are registered. A yield sampled with `instr_valid` high shows its result in the following cycle for one cycle only. A cycle with `instr_valid` low leaves every pulse output low in the next cycle.
- R3: An operand of 0 with an eligible peer gives action kind 0 (release) and a one-hot `tc_clear` bit at the current context. A peer is eligible when it is on the same virtual processor, is not the current context, is dynamically allocatable, is not halted and is active.
- R4: An operand of 0 with no eligible peer raises a thread exception with cause 0 and no action.
- R5: An operand of all-ones gives action kind 1 (reschedule). All-ones minus one gives action kind 3 (poll), and the intercept enables never affect a poll.
- R6: A positive operand whose bits all lie inside the mask gives action kind 2 (wait), with `wait_cond` equal to the operand's low bits ANDed with the mask.
- R7: A positive operand with any bit set outside the mask raises a thread exception with cause 2.
- R8: For an operand of 0, all-ones or positive, where no earlier exception applies, having both intercept enables set raises a thread exception with cause 4 in place of the action.
- R9: When multithreading is disabled, or when the operand is negative but neither all-ones nor all-ones minus one, a reserved-instruction exception is raised. This check takes priority over every thread exception.
- R10: An action with a nonzero destination index asserts `wb_en` with `wb_idx` set to that index and `wb_data` equal to `qual_in` ANDed with the mask, zero-extended. An exception, or a destination index of 0, gives no write.
- R11: Each instruction produces at most one of: action, thread exception, reserved exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| rt_value | input | 32 | Operand value selecting the yield outcome |
| mt_enable | input | 1 | Multithreading enabled |
| qual_mask | input | QW (31) | Qualifier enable mask |
| qual_in | input | QW (31) | Live qualifier condition inputs |
| sched_intercept | input | 1 | Virtual-processor scheduler intercept enable |
| tc_intercept | input | 1 | Current context's intercept enable |
| cur_tc | input | TCW (2) | Index of the issuing context |
| tc_vpe | input | NUM_TC*VPE_W (4) | Virtual processor binding per context |
| tc_dyn | input | NUM_TC (4) | Context is dynamically allocatable |
| tc_halted | input | NUM_TC (4) | Context is halted |
| tc_active | input | NUM_TC (4) | Context is active |
| act_valid | output | 1 | Action pulse |
| act_kind | output | 2 | 0 release, 1 reschedule, 2 wait, 3 poll |
| wait_cond | output | QW (31) | Qualifier condition to wait on |
| tc_clear | output | NUM_TC (4) | Active bit to clear on release |
| thr_exc | output | 1 | Thread exception pulse |
| exc_cause | output | 3 | Thread exception cause (0, 2, 4) |
| rsv_exc | output | 1 | Reserved-instruction exception pulse |
| wb_en | output | 1 | Register write request |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Masked qualifier inputs |

## Verification
Every cycle, the assertions check the relationships between outputs that must always hold. These are: the exclusivity of the three outcomes, quiet outputs after an idle cycle, a nonzero write index only with an action, one-hot clear bits on a release, and that each exception cause agrees with the operand, mask and intercept inputs of the cycle before. Only the bench scenarios can show the correct decision itself. That covers the exact operand encodings, the priority between causes when several apply, the peer-eligibility corners (other virtual processor, halted, not allocatable), the decode rejecting near-miss words, and the exact data written back.

// File: rtl/yield_pkg.sv
package yield_pkg;

    // Fixed instruction field values that identify a yield
    localparam logic [5:0] MAJOR_OPC = 6'h00;
    localparam logic [1:0] PAD_BITS  = 2'b00;
    localparam logic [7:0] MINOR_OPC = 8'h26;
    localparam logic [5:0] POOL_SEL  = 6'h3C;

    localparam logic [31:0] RT_RESCHED = 32'hFFFF_FFFF;
    localparam logic [31:0] RT_POLL    = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        ACT_FREE    = 2'd0,
        ACT_RESCHED = 2'd1,
        ACT_WAIT    = 2'd2,
        ACT_POLL    = 2'd3
    } yact_e;

    typedef enum logic [2:0] {
        CAUSE_UNDERFLOW = 3'd0,
        CAUSE_BADQUAL   = 3'd2,
        CAUSE_INTERCEPT = 3'd4
    } ycause_e;

    typedef enum logic [2:0] {
        OPC_FREE,
        OPC_RESCHED,
        OPC_POLL,
        OPC_WAIT,
        OPC_BAD
    } rtclass_e;

    typedef struct packed {
        logic    act;
        yact_e   kind;
        logic    thr_exc;
        ycause_e cause;
        logic    rsv_exc;
        logic    wb;
    } yres_t;

    function automatic logic is_yield(input logic [31:0] w);
        return (w[31:26] == MAJOR_OPC) && (w[15:14] == PAD_BITS) &&
               (w[13:6] == MINOR_OPC) && (w[5:0] == POOL_SEL);
    endfunction

    function automatic rtclass_e classify(input logic [31:0] v);
        rtclass_e c;
        if (v == 32'd0)             c = OPC_FREE;
        else if (v == RT_RESCHED)   c = OPC_RESCHED;
        else if (v == RT_POLL)      c = OPC_POLL;
        else if (!v[31])            c = OPC_WAIT;
        else                        c = OPC_BAD;
        return c;
    endfunction

endpackage

// File: rtl/yield_decode.sv
module yield_decode
    import yield_pkg::*;
(
    input  logic [31:0] instr_word,
    input  logic [31:0] rt_value,
    output logic        hit,
    output logic [4:0]  rs_idx,
    output rtclass_e    rt_class
);

    always_comb begin
        hit      = is_yield(instr_word);
        rs_idx   = instr_word[20:16];
        rt_class = classify(rt_value);
    end

endmodule

// File: rtl/yield_peer_scan.sv
module yield_peer_scan #(
    parameter int NUM_TC = 4,
    parameter int VPE_W  = 1,
    localparam int TCW   = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
    input  logic [TCW-1:0]          cur_tc,
    input  logic [NUM_TC*VPE_W-1:0] tc_vpe,
    input  logic [NUM_TC-1:0]       tc_dyn,
    input  logic [NUM_TC-1:0]       tc_halted,
    input  logic [NUM_TC-1:0]       tc_active,
    output logic                    peer_found
);

    logic [VPE_W-1:0]  own_vpe;
    logic [NUM_TC-1:0] eligible;

    always_comb begin
        own_vpe = tc_vpe[cur_tc*VPE_W +: VPE_W];
    end

    for (genvar t = 0; t < NUM_TC; t++) begin : g_tc
        always_comb begin
            eligible[t] = (tc_vpe[t*VPE_W +: VPE_W] == own_vpe) &&
                          (TCW'(t) != cur_tc) &&
                          tc_dyn[t] && !tc_halted[t] && tc_active[t];
        end
    end

    assign peer_found = |eligible;

endmodule

// File: rtl/yield_resolve.sv
module yield_resolve
    import yield_pkg::*;
#(
    parameter int QW = 31
) (
    input  logic          hit,
    input  rtclass_e      rt_class,
    input  logic [31:0]   rt_value,
    input  logic [4:0]    rs_idx,
    input  logic          mt_enable,
    input  logic [QW-1:0] qual_mask,
    input  logic          sched_intercept,
    input  logic          tc_intercept,
    input  logic          peer_found,
    output yres_t         res,
    output logic [QW-1:0] wait_cond
);

    logic [30:0] mask_ext;
    logic        bad_qual;
    logic        invoke;

    always_comb begin
        mask_ext = 31'(qual_mask);
        bad_qual = |(rt_value[30:0] & ~mask_ext);
    end

    always_comb begin
        res       = '{act: 1'b0, kind: ACT_FREE, thr_exc: 1'b0,
                      cause: CAUSE_UNDERFLOW, rsv_exc: 1'b0, wb: 1'b0};
        wait_cond = '0;
        invoke    = 1'b0;
        if (hit) begin
            if (!mt_enable || rt_class == OPC_BAD) begin
                res.rsv_exc = 1'b1;
            end else begin
                unique case (rt_class)
                    OPC_FREE: begin
                        if (!peer_found) begin
                            res.thr_exc = 1'b1;
                            res.cause   = CAUSE_UNDERFLOW;
                        end else begin
                            invoke   = 1'b1;
                            res.kind = ACT_FREE;
                        end
                    end
                    OPC_RESCHED: begin
                        invoke   = 1'b1;
                        res.kind = ACT_RESCHED;
                    end
                    OPC_POLL: begin
                        res.kind = ACT_POLL;
                    end
                    default: begin
                        if (bad_qual) begin
                            res.thr_exc = 1'b1;
                            res.cause   = CAUSE_BADQUAL;
                        end else begin
                            invoke    = 1'b1;
                            res.kind  = ACT_WAIT;
                            wait_cond = rt_value[QW-1:0] & qual_mask;
                        end
                    end
                endcase
                if (invoke && sched_intercept && tc_intercept) begin
                    res.thr_exc = 1'b1;
                    res.cause   = CAUSE_INTERCEPT;
                end
                if (!res.thr_exc) begin
                    res.act = 1'b1;
                    res.wb  = (rs_idx != 5'd0);
                end else begin
                    wait_cond = '0;
                end
            end
        end
    end

endmodule

// File: rtl/thread_yield_ctrl.sv
module thread_yield_ctrl
    import yield_pkg::*;
#(
    parameter int NUM_TC = 4,
    parameter int VPE_W  = 1,
    parameter int QW     = 31,
    localparam int TCW   = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    instr_valid,
    input  logic [31:0]             instr_word,
    input  logic [31:0]             rt_value,
    input  logic                    mt_enable,
    input  logic [QW-1:0]           qual_mask,
    input  logic [QW-1:0]           qual_in,
    input  logic                    sched_intercept,
    input  logic                    tc_intercept,
    input  logic [TCW-1:0]          cur_tc,
    input  logic [NUM_TC*VPE_W-1:0] tc_vpe,
    input  logic [NUM_TC-1:0]       tc_dyn,
    input  logic [NUM_TC-1:0]       tc_halted,
    input  logic [NUM_TC-1:0]       tc_active,
    output logic                    act_valid,
    output logic [1:0]              act_kind,
    output logic [QW-1:0]           wait_cond,
    output logic [NUM_TC-1:0]       tc_clear,
    output logic                    thr_exc,
    output logic [2:0]              exc_cause,
    output logic                    rsv_exc,
    output logic                    wb_en,
    output logic [4:0]              wb_idx,
    output logic [31:0]             wb_data
);

    logic          dec_hit;
    logic [4:0]    dec_rs;
    rtclass_e      dec_class;
    logic          peer_found;
    yres_t         res_d;
    yres_t         res_q;
    logic [QW-1:0] wait_d;
    logic [QW-1:0] wait_q;
    logic [NUM_TC-1:0] clear_q;
    logic [4:0]    idx_q;
    logic [31:0]   data_q;

    yield_decode u_decode (
        .instr_word (instr_word),
        .rt_value   (rt_value),
        .hit        (dec_hit),
        .rs_idx     (dec_rs),
        .rt_class   (dec_class)
    );

    yield_peer_scan #(.NUM_TC(NUM_TC), .VPE_W(VPE_W)) u_peers (
        .cur_tc     (cur_tc),
        .tc_vpe     (tc_vpe),
        .tc_dyn     (tc_dyn),
        .tc_halted  (tc_halted),
        .tc_active  (tc_active),
        .peer_found (peer_found)
    );

    yield_resolve #(.QW(QW)) u_resolve (
        .hit             (dec_hit && instr_valid),
        .rt_class        (dec_class),
        .rt_value        (rt_value),
        .rs_idx          (dec_rs),
        .mt_enable       (mt_enable),
        .qual_mask       (qual_mask),
        .sched_intercept (sched_intercept),
        .tc_intercept    (tc_intercept),
        .peer_found      (peer_found),
        .res             (res_d),
        .wait_cond       (wait_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '{act: 1'b0, kind: ACT_FREE, thr_exc: 1'b0,
                         cause: CAUSE_UNDERFLOW, rsv_exc: 1'b0, wb: 1'b0};
            wait_q  <= '0;
            clear_q <= '0;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            res_q   <= res_d;
            wait_q  <= wait_d;
            clear_q <= (res_d.act && res_d.kind == ACT_FREE)
                       ? (NUM_TC'(1) << cur_tc) : '0;
            idx_q   <= res_d.wb ? dec_rs : 5'd0;
            data_q  <= res_d.wb ? 32'(qual_in & qual_mask) : 32'd0;
        end
    end

    assign act_valid = res_q.act;
    assign act_kind  = res_q.kind;
    assign wait_cond = wait_q;
    assign tc_clear  = clear_q;
    assign thr_exc   = res_q.thr_exc;
    assign exc_cause = res_q.cause;
    assign rsv_exc   = res_q.rsv_exc;
    assign wb_en     = res_q.wb;
    assign wb_idx    = idx_q;
    assign wb_data   = data_q;

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !(act_valid || thr_exc || rsv_exc || wb_en));

    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_valid, thr_exc, rsv_exc}));

    // R4
    underflow_src_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_exc && exc_cause == 3'd0) |-> $past(rt_value) == 32'd0);

    // R7
    badqual_src_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_exc && exc_cause == 3'd2) |->
        ($past(rt_value[30:0]) & ~31'($past(qual_mask))) != 31'd0);

    // R8
    intercept_src_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_exc && exc_cause == 3'd4) |->
        ($past(sched_intercept) && $past(tc_intercept)));

    // R10
    wb_idx_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != 5'd0 && act_valid));

    // R3
    free_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_kind == 2'd0) |-> $countones(tc_clear) == 1);

    // R3
    clear_only_free_chk: assert property (@(posedge clk) disable iff (rst)
        !(act_valid && act_kind == 2'd0) |-> tc_clear == '0);

endmodule

// File: tb/thread_yield_ctrl_tb.sv
module thread_yield_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_TC = 4;
    localparam int QW     = 31;
    localparam logic [30:0] QIN  = 31'h0000_0F5A;
    localparam logic [30:0] MSK8 = 31'h0000_00FF;

    typedef struct packed {
        logic [31:0] rt;
        logic [4:0]  rs;
        logic        mt;
        logic        si;
        logic        ti;
        logic        peers;
        logic [30:0] mask;
        logic        ex_t;
        logic        ex_r;
        logic [2:0]  cause;
        logic        act;
        logic [1:0]  kind;
        logic        wb;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b0, 3'd0, 1'b1, 2'd0, 1'b1},
        '{32'h0000_0000, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, MSK8, 1'b1, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0},
        '{32'hFFFF_FFFF, 5'd6, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b0, 3'd0, 1'b1, 2'd1, 1'b1},
        '{32'hFFFF_FFFE, 5'd7, 1'b1, 1'b1, 1'b1, 1'b1, MSK8, 1'b0, 1'b0, 3'd0, 1'b1, 2'd3, 1'b1},
        '{32'hFFFF_FFFF, 5'd6, 1'b1, 1'b1, 1'b1, 1'b1, MSK8, 1'b1, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0000, 5'd6, 1'b1, 1'b1, 1'b1, 1'b1, MSK8, 1'b1, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0000, 5'd6, 1'b1, 1'b1, 1'b1, 1'b0, MSK8, 1'b1, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0011, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b0, 3'd0, 1'b1, 2'd2, 1'b1},
        '{32'h0000_0100, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b1, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0100, 5'd9, 1'b1, 1'b1, 1'b1, 1'b1, MSK8, 1'b1, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0011, 5'd9, 1'b1, 1'b1, 1'b1, 1'b1, MSK8, 1'b1, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0},
        '{32'hFFFF_FFFD, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0100, 5'd9, 1'b0, 1'b1, 1'b1, 1'b1, MSK8, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0, 1'b0},
        '{32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b0, 3'd0, 1'b1, 2'd1, 1'b0},
        '{32'h7FFF_FFFF, 5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 31'h7FFF_FFFF, 1'b0, 1'b0, 3'd0, 1'b1, 2'd2, 1'b1},
        '{32'h8000_0000, 5'd3, 1'b1, 1'b0, 1'b0, 1'b1, MSK8, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              instr_valid;
    logic [31:0]       instr_word;
    logic [31:0]       rt_value;
    logic              mt_enable;
    logic [QW-1:0]     qual_mask;
    logic [QW-1:0]     qual_in;
    logic              sched_intercept;
    logic              tc_intercept;
    logic [1:0]        cur_tc;
    logic [NUM_TC-1:0] tc_vpe;
    logic [NUM_TC-1:0] tc_dyn;
    logic [NUM_TC-1:0] tc_halted;
    logic [NUM_TC-1:0] tc_active;
    logic              act_valid;
    logic [1:0]        act_kind;
    logic [QW-1:0]     wait_cond;
    logic [NUM_TC-1:0] tc_clear;
    logic              thr_exc;
    logic [2:0]        exc_cause;
    logic              rsv_exc;
    logic              wb_en;
    logic [4:0]        wb_idx;
    logic [31:0]       wb_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    thread_yield_ctrl #(.NUM_TC(NUM_TC), .VPE_W(1), .QW(QW)) u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .rt_value(rt_value), .mt_enable(mt_enable), .qual_mask(qual_mask),
        .qual_in(qual_in), .sched_intercept(sched_intercept),
        .tc_intercept(tc_intercept), .cur_tc(cur_tc), .tc_vpe(tc_vpe),
        .tc_dyn(tc_dyn), .tc_halted(tc_halted), .tc_active(tc_active),
        .act_valid(act_valid), .act_kind(act_kind), .wait_cond(wait_cond),
        .tc_clear(tc_clear), .thr_exc(thr_exc), .exc_cause(exc_cause),
        .rsv_exc(rsv_exc), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] mk_word(input logic [4:0] rs);
        return {6'h00, 5'd7, rs, 2'b00, 8'h26, 6'h3C};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_peers(input logic on);
        tc_vpe    = 4'b0000;
        tc_dyn    = 4'b1111;
        tc_halted = 4'b0000;
        tc_active = on ? 4'b1011 : 4'b0010;
    endtask

    task automatic issue(input logic [31:0] word, input logic [31:0] rt);
        @(negedge clk);
        instr_word  = word;
        rt_value    = rt;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        check(tag, {28'd0, act_valid, thr_exc, rsv_exc, wb_en}, 32'd0);
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.ex_r)                    return "R9";
        if (v.ex_t && v.cause == 3'd0) return "R4";
        if (v.ex_t && v.cause == 3'd2) return "R7";
        if (v.ex_t)                    return "R8";
        if (v.kind == 2'd0)            return "R3";
        if (v.kind == 2'd2)            return "R6";
        return "R5";
    endfunction

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0; rt_value = '0;
        mt_enable = 1'b1; qual_mask = MSK8; qual_in = QIN;
        sched_intercept = 1'b0; tc_intercept = 1'b0; cur_tc = 2'd1;
        set_peers(1'b1);
        repeat (3) @(negedge clk);
        expect_none("R2 reset state");
        check("R2 reset clear", {28'd0, tc_clear}, 32'd0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            mt_enable = VECS[i].mt;
            sched_intercept = VECS[i].si;
            tc_intercept = VECS[i].ti;
            qual_mask = VECS[i].mask;
            set_peers(VECS[i].peers);
            issue(mk_word(VECS[i].rs), VECS[i].rt);
            check({tag_of(VECS[i]), " R11 outcome"}, {29'd0, act_valid, thr_exc, rsv_exc},
                  {29'd0, VECS[i].act, VECS[i].ex_t, VECS[i].ex_r});
            if (VECS[i].ex_t)
                check({tag_of(VECS[i]), " cause"}, {29'd0, exc_cause}, {29'd0, VECS[i].cause});
            if (VECS[i].act)
                check({tag_of(VECS[i]), " kind"}, {30'd0, act_kind}, {30'd0, VECS[i].kind});
            if (VECS[i].act && VECS[i].kind == 2'd2)
                check("R6 wait_cond", {1'b0, wait_cond}, {1'b0, VECS[i].rt[30:0] & VECS[i].mask});
            check("R10 wb_en", {31'd0, wb_en}, {31'd0, VECS[i].wb});
            if (VECS[i].wb) begin
                check("R10 wb_idx", {27'd0, wb_idx}, {27'd0, VECS[i].rs});
                check("R10 wb_data", wb_data, {1'b0, QIN & VECS[i].mask});
            end
            check("R3 clear", {28'd0, tc_clear},
                  (VECS[i].act && VECS[i].kind == 2'd0) ? 32'h2 : 32'h0);
        end

        // R2 pulse lasts one cycle
        mt_enable = 1'b1; sched_intercept = 1'b0; tc_intercept = 1'b0;
        qual_mask = MSK8; set_peers(1'b1);
        issue(mk_word(5'd4), 32'hFFFF_FFFF);
        check("R2 pulse high", {31'd0, act_valid}, 32'd1);
        @(negedge clk);
        expect_none("R2 pulse low");

        // R2 valid low ignores a yield word
        @(negedge clk);
        instr_word = mk_word(5'd4); rt_value = 32'hFFFF_FFFF; instr_valid = 1'b0;
        @(negedge clk);
        expect_none("R2 invalid ignored");

        // R1 near-miss words
        issue(mk_word(5'd4) ^ 32'h0000_0001, 32'hFFFF_FFFF);
        expect_none("R1 minor field");
        issue(mk_word(5'd4) ^ 32'h0000_0040, 32'hFFFF_FFFF);
        expect_none("R1 sub opcode");
        issue(mk_word(5'd4) ^ 32'h0000_4000, 32'hFFFF_FFFF);
        expect_none("R1 pad bits");
        issue(mk_word(5'd4) ^ 32'h8000_0000, 32'hFFFF_FFFF);
        expect_none("R1 major opcode");
        issue(mk_word(5'd4) ^ 32'h8000_0000, 32'h0000_0000);
        expect_none("R1 major opcode release");

        // R3/R4 peer eligibility corners
        tc_vpe = 4'b1000; tc_dyn = 4'b1111; tc_halted = 4'b0000; tc_active = 4'b1010;
        issue(mk_word(5'd4), 32'd0);
        check("R4 peer other vpe", {30'd0, thr_exc, act_valid}, 32'h2);
        tc_vpe = 4'b0000; tc_halted = 4'b1000;
        issue(mk_word(5'd4), 32'd0);
        check("R4 peer halted", {30'd0, thr_exc, act_valid}, 32'h2);
        tc_halted = 4'b0000; tc_dyn = 4'b0111;
        issue(mk_word(5'd4), 32'd0);
        check("R4 peer not dynamic", {30'd0, thr_exc, act_valid}, 32'h2);
        tc_dyn = 4'b1111;
        issue(mk_word(5'd4), 32'd0);
        check("R3 peer ok", {30'd0, thr_exc, act_valid}, 32'h1);
        check("R3 clear bit", {28'd0, tc_clear}, 32'h2);
        cur_tc = 2'd3; tc_active = 4'b1001;
        issue(mk_word(5'd4), 32'd0);
        check("R3 clear cur3", {28'd0, tc_clear}, 32'h8);

        // R9 reserved priority over a release underflow
        mt_enable = 1'b0; tc_active = 4'b1000;
        issue(mk_word(5'd4), 32'd0);
        check("R9 mt off", {29'd0, act_valid, thr_exc, rsv_exc}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule